// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block is a counter fed by a single timer input pin. It runs in one of two modes. In edge-counting mode it adds one for each edge of the chosen direction on the pin. In gated mode it adds one for each pulse of a divide-by-64 bus-clock tick, but only while the pin is at its active level. It suits event counting, pulse-width measurement and interval timing.

One polarity bit controls both modes. In edge-counting mode it picks the counted edge. In gated mode it picks the active level, and the edge that ends an active interval raises the input-edge flag. The count register can be written at any time. Software can load it with the two's complement of a tick count, and the overflow flag then serves as a delay timer. Each of the two sticky flags has its own interrupt enable, and the flags are cleared by writing 1 to them.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0x0000, both flags are 0 and `irq` is 0.
- R2: In edge-counting mode (`cfg_gated`=0) with the accumulator enabled, each falling edge of the pin adds one when `cfg_pol`=0. Each rising edge adds one when `cfg_pol`=1. Edges of the other direction have no effect.
- R3: In gated mode (`cfg_gated`=1) with the accumulator enabled, each cycle in which `tick64`=1 adds one while the synchronised pin is high (`cfg_pol`=0) or low (`cfg_pol`=1). Ticks at the inactive level have no effect.
- R4: While the accumulator is enabled, in either mode, a falling edge (`cfg_pol`=0) or a rising edge (`cfg_pol`=1) of the synchronised pin sets `edge_flag`. In gated mode that edge is the end of the active interval.
- R5: While `cfg_en` is 0 the count changes only through software writes, and pin edges set no flag.
- R6: An increment from 0xFFFF to 0x0000 sets `ovf_flag`. After a preload of 0x10000−K in gated mode, the flag is still clear after K−1 active ticks and is set after exactly K, with the count then at 0x0000.
- R7: With `flag_clr_we`=1, a 1 in `flag_clr[0]` clears `ovf_flag` and a 1 in `flag_clr[1]` clears `edge_flag`. A 0 bit leaves its flag as it was. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq` is 1 exactly when (`ovf_flag` and the stored overflow enable) or (`edge_flag` and the stored edge enable) is true.
- R9: A count write (`cnt_we`) takes effect on the next clock edge. If it coincides with an increment, the written value is kept and no overflow is flagged.
- R10: The pin passes through two synchroniser flops. An edge driven before clock edge k changes the count at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous timer input pin |
| tick64 | input | 1 | One-cycle divide-by-64 tick |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_en | input | 1 | Accumulator enable |
| cfg_gated | input | 1 | 0 = edge counting, 1 = gated time |
| cfg_pol | input | 1 | Edge / active-level select |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_edge_ie | input | 1 | Input-edge interrupt enable |
| cnt_we | input | 1 | Write strobe for the count |
| cnt_wdata | input | 16 | Value written to the count |
| flag_clr_we | input | 1 | Write strobe for flag clearing |
| flag_clr | input | 2 | Write-1-to-clear: bit0 overflow, bit1 input edge |
| count | output | 16 | Current accumulator value |
| ovf_flag | output | 1 | Sticky overflow flag |
| edge_flag | output | 1 | Sticky input-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The corner cases that are hardest to reach are those where two sources act in the same cycle. One is a count write landing on the same clock edge as a gated increment at 0xFFFF. The other is a flag clear landing on the cycle that sets the flag. The bench reaches them by holding the pin at the active level long enough to clear the synchroniser, loading 0xFFFF, and then raising `tick64` together with `cnt_we` or `flag_clr_we` on one falling clock edge. The delay-timer use is covered by sweeping the preload so that the overflow lands on exactly the K-th active tick.

// File: rtl/pacc_pkg.sv
// Package: shared widths and the configuration record for the accumulator.
// Assumes: a single clock domain apart from the raw pin.
package pacc_pkg;
    localparam int CNT_W = 16;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic en;
        logic gated;
        logic pol;
        logic ovf_ie;
        logic edge_ie;
    } pacc_cfg_t;
endpackage

// File: rtl/pacc_sync.sv
// Module: pacc_sync
// Brings the asynchronous pin into the clock domain through a chain of flops
// and reports rising/falling edges of the synchronised level.
// Assumes: the pin is low during reset, so no edge is reported on reset exit.
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_raw;
    end

    // Remaining stages shift the sample along the chain.
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/pacc_counter.sv
// Module: pacc_counter
// The accumulator register: a software write or an increment, the write
// taking priority. Reports a wrap when an accepted increment leaves all ones.
// Assumes: inc is a single-cycle qualified request.
module pacc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    // A software write overrides a same-cycle increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (wr)  value <= wdata;
        else if (inc) value <= value + 1'b1;
    end

    assign wrap = inc & ~wr & (value == ALL_ONES);
endmodule

// File: rtl/pacc_flags.sv
// Module: pacc_flags
// Two sticky flags with write-1-to-clear and an interrupt request.
// Assumes: a set request wins over a clear in the same cycle.
module pacc_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ovf,
    input  logic       set_edge,
    input  logic       clr_we,
    input  logic [1:0] clr,
    input  logic       ovf_ie,
    input  logic       edge_ie,
    output logic       ovf,
    output logic       edge_f,
    output logic       irq
);
    // Overflow flag: set wins, then write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (set_ovf)          ovf <= 1'b1;
        else if (clr_we && clr[0]) ovf <= 1'b0;
    end

    // Input-edge flag: same policy on bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                edge_f <= 1'b0;
        else if (set_edge)         edge_f <= 1'b1;
        else if (clr_we && clr[1]) edge_f <= 1'b0;
    end

    assign irq = (ovf & ovf_ie) | (edge_f & edge_ie);
endmodule

// File: rtl/pulse_accum.sv
// Module: pulse_accum (top)
// Pin-driven accumulator with edge-counting and gated-time modes, sticky
// flags and an interrupt request.
// Assumes: tick64 is a one-cycle pulse from the clock divider.
module pulse_accum
    import pacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             tick64,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic             cfg_gated,
    input  logic             cfg_pol,
    input  logic             cfg_ovf_ie,
    input  logic             cfg_edge_ie,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr_we,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             edge_flag,
    output logic             irq
);
    pacc_cfg_t cfg_q;
    logic      lvl, rise, fall;
    logic      sel_edge, active, inc, wrap;

    // Configuration register, loaded as a whole on cfg_we.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= '{en: cfg_en, gated: cfg_gated, pol: cfg_pol,
                                    ovf_ie: cfg_ovf_ie, edge_ie: cfg_edge_ie};
    end

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    // Selected edge and active level both follow the polarity bit.
    always_comb begin
        sel_edge = cfg_q.pol ? rise : fall;
        active   = cfg_q.pol ? ~lvl : lvl;
        if (!cfg_q.en)        inc = 1'b0;
        else if (cfg_q.gated) inc = tick64 & active;
        else                  inc = sel_edge;
    end

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr(cnt_we),
        .wdata(cnt_wdata), .value(count), .wrap(wrap)
    );

    pacc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_ovf(wrap),
        .set_edge(cfg_q.en & sel_edge), .clr_we(flag_clr_we), .clr(flag_clr),
        .ovf_ie(cfg_q.ovf_ie), .edge_ie(cfg_q.edge_ie),
        .ovf(ovf_flag), .edge_f(edge_flag), .irq(irq)
    );
endmodule

// File: rtl/pulse_accum_checker.sv
// Module: pulse_accum_checker
// Temporal properties of the accumulator, attached to the top via bind.
// Assumes: reset is asserted from time zero.
module pulse_accum_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_q,
    input logic         cnt_we,
    input logic [W-1:0] cnt_wdata,
    input logic         flag_clr_we,
    input logic [1:0]   flag_clr,
    input logic [W-1:0] count,
    input logic         ovf_flag,
    input logic         edge_flag,
    input logic         irq
);
    localparam logic [W-1:0] ONES = '1;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count == $past(cnt_wdata)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (count == $past(count) || count == $past(count) + 1'b1)); // R2
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_we) |=> $stable(count)); // R5
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && count == ONES) |=> (count != '0 || ovf_flag)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(flag_clr_we && flag_clr[0])) |=> ovf_flag); // R7
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flag && !(flag_clr_we && flag_clr[1])) |=> edge_flag); // R7
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !edge_flag) |-> !irq); // R8
endmodule

bind pulse_accum pulse_accum_checker #(.W(pacc_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(cfg_q.en), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .edge_flag(edge_flag), .irq(irq)
);

// File: tb/pulse_accum_test.sv
module pulse_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, tick64 = 1'b0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_gated = 1'b0, cfg_pol = 1'b0;
    logic        cfg_ovf_ie = 1'b0, cfg_edge_ie = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        flag_clr_we = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic [15:0] count;
    logic        ovf_flag, edge_flag, irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pulse_accum uut (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic g, input logic p,
                           input logic oie, input logic eie);
        cfg_en = en; cfg_gated = g; cfg_pol = p; cfg_ovf_ie = oie; cfg_edge_ie = eie;
        cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_wdata = v; cnt_we = 1'b1; step(1); cnt_we = 1'b0;
    endtask

    task automatic clr(input logic [1:0] b);
        flag_clr = b; flag_clr_we = 1'b1; step(1); flag_clr_we = 1'b0; flag_clr = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick64 = 1'b1; step(1); tick64 = 1'b0; step(1);
        end
    endtask

    task automatic pulse();
        pin_in = 1'b1; step(4); pin_in = 1'b0; step(4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 count", count, 0);
        chk("R1 flags", {ovf_flag, edge_flag, irq}, 0);

        // R2/R4: edge-counting sweep over both polarities and pulse counts
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 6; n++) begin
                set_cfg(1'b1, 1'b0, p[0], 1'b0, 1'b0);
                wr_cnt(16'h0000); clr(2'b11);
                for (int k = 0; k < n; k++) pulse();
                chk("R2 edge count", count, n);
                chk("R4 edge flag event", edge_flag, (n > 0));
            end
        end

        // R10: latency from pin edge to count
        set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        wr_cnt(16'h0010);
        pin_in = 1'b1; step(2);
        chk("R10 not yet", count, 16'h0010);
        step(1);
        chk("R10 counted", count, 16'h0011);
        pin_in = 1'b0; step(4);

        // R5: disabled accumulator ignores pulses and ticks
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        wr_cnt(16'h0005); clr(2'b11);
        pulse(); pulse();
        chk("R5 event disabled", count, 5);
        chk("R5 no flag", edge_flag, 0);
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        pin_in = 1'b1; step(4); ticks(3); pin_in = 1'b0; step(4);
        chk("R5 gated disabled", count, 5);

        // R3/R4: gated sweep over both polarities
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 6; m++) begin
                set_cfg(1'b1, 1'b1, p[0], 1'b0, 1'b0);
                pin_in = p[0]; step(5);
                wr_cnt(16'h0000); clr(2'b11);
                ticks(3);
                pin_in = ~p[0]; step(4);
                ticks(m);
                pin_in = p[0]; step(4);
                ticks(2);
                chk("R3 gated count", count, m);
                chk("R4 trailing edge flag", edge_flag, 1);
            end
        end
        pin_in = 1'b0; step(4);

        // R6: preload as delay timer, with R8 overflow interrupt
        for (int t = 0; t < 3; t++) begin
            int k;
            k = (t == 0) ? 1 : (t == 1) ? 3 : 7;
            set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
            pin_in = 1'b1; step(4);
            wr_cnt(16'(32'h10000 - k)); clr(2'b11);
            ticks(k - 1);
            chk("R6 no early ovf", ovf_flag, 0);
            chk("R8 irq low", irq, 0);
            ticks(1);
            chk("R6 ovf at K", ovf_flag, 1);
            chk("R6 count zero", count, 0);
            chk("R8 irq ovf", irq, 1);
        end

        // R7: write 0 keeps, write 1 clears; R8 edge interrupt mapping
        clr(2'b10);
        chk("R7 zero bit keeps", ovf_flag, 1);
        clr(2'b01);
        chk("R7 one bit clears", ovf_flag, 0);
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pin_in = 1'b0; step(4);
        chk("R8 edge irq", {edge_flag, irq}, 2'b11);
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 edge irq masked", irq, 0);
        clr(2'b10);
        chk("R7 edge cleared", edge_flag, 0);

        // R9: write coinciding with an increment, including at the wrap point
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        pin_in = 1'b1; step(4); clr(2'b11);
        tick64 = 1'b1; cnt_wdata = 16'h1234; cnt_we = 1'b1; step(1);
        tick64 = 1'b0; cnt_we = 1'b0;
        chk("R9 write wins", count, 16'h1234);
        wr_cnt(16'hFFFF);
        tick64 = 1'b1; cnt_wdata = 16'hFFFF; cnt_we = 1'b1; step(1);
        tick64 = 1'b0; cnt_we = 1'b0;
        chk("R9 write at wrap", count, 16'hFFFF);
        chk("R9 no ovf", ovf_flag, 0);

        // R7: set wins over clear in the same cycle
        tick64 = 1'b1; flag_clr = 2'b01; flag_clr_we = 1'b1; step(1);
        tick64 = 1'b0; flag_clr_we = 1'b0;
        chk("R7 set beats clear", ovf_flag, 1);
        chk("R6 wrapped", count, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule